// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller

This block decodes the clocked control pins of a no-wait-state synchronous burst SRAM and owns a small four-byte-lane memory behind them. At each rising clock edge it reads three chip enables, the advance/load pin, write enable, the per-lane byte-write selects, clock enable and the sleep pin. From these it picks one operation: deselect, begin or continue a read, begin or continue a write, write abort, stall, sleep, or wake-up hold. Each begin loads an address. Each continue steps a two-bit burst counter in linear or interleaved order.

Read data is registered at the edge that accepts the read. The bus drivers are split into a data-out word, an enable and a data-in word, so the pad ring above can build the tri-state bus. The enable combines a registered "read cycle active" flag with the output-enable and sleep pins without passing through a clock. This means output enable acts at once. Output enable is also masked during every write cycle, even a partial one. Dummy reads, which are reads with output enable off, move through a burst exactly as normal reads do.

Top module: `sram_burst_ctrl`

## Requirements
- R1: With adv_ld_i low, any of ce1_ni high, ce2_i low or ce3_ni high gives a deselect. The bus enable is 0 after that edge and any open burst ends.
- R2: Chip selected, adv_ld_i low and we_ni high begin a read at addr_i. After that edge dq_o equals the stored word and dq_oe_o is 1 while oe_ni is low.
- R3: With burst_mode_i = 0, each continue cycle (adv_ld_i high) uses the next address in linear order. The low two bits count up modulo 4 from the loaded value and the upper bits stay fixed.
- R4: With burst_mode_i = 1, continue cycles use interleaved order. The low two bits equal the loaded low bits XOR the burst count (1, 2, 3, 0 …).
- R5: A write begins with adv_ld_i low, we_ni low and at least one bw_ni bit low. Lane k takes dq_i[8k+7:8k] exactly when bw_ni[k] is 0, and the other lanes keep their contents. Continue cycles of a write burst write the next burst address the same way.
- R6: The bus enable is 0 after every write or write-abort cycle, whatever oe_ni is.
- R7: A write cycle with all four bw_ni bits high changes no memory contents. A begin of this kind ends the burst. A continue of this kind still steps the burst address.
- R8: dq_oe_o follows oe_ni during a read with no clock edge in between.
- R9: A read with oe_ni high (dummy read) steps the burst address exactly like a read with oe_ni low.
- R10: With cen_ni high, the edge is ignored. Read data, bus state, burst type and burst address are all held.
- R11: While zz_i is high, dq_oe_o is 0 at once and all other inputs are ignored. The first two edges after zz_i falls accept no command, and the block comes back deselected.
- R12: After reset the block is deselected and dq_oe_o is 0 even with oe_ni low.
- R13: A continue cycle after a deselect stays deselected, whatever the chip enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce1_ni | input | 1 | Chip enable 1, active low |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| adv_ld_i | input | 1 | 1 = continue burst, 0 = load new command |
| we_ni | input | 1 | Write enable, active low |
| bw_ni | input | 4 | Byte-lane write selects, active low |
| cen_ni | input | 1 | Clock enable, active low; high stalls |
| oe_ni | input | 1 | Output enable, active low, unclocked |
| zz_i | input | 1 | Sleep request, active high |
| burst_mode_i | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_i | input | 6 | Word address for a begin cycle |
| dq_i | input | 32 | Write data from the bus |
| dq_o | output | 32 | Read data to the bus drivers |
| dq_oe_o | output | 1 | Bus driver enable |

## Verification
The tricky overlaps are between sleep handling and the other controls. A stall can fall inside the two-edge wake-up window. The sleep pin can also rise while a read burst is driving the bus, so the unclocked enable path and a clocked state change act in the same cycle. The random stream raises zz_i and cen_ni on their own, so they collide with bursts and with each other. Directed sequences raise sleep mid-read, release it and issue reads in the blocked edges. A reference model of the pin rules decides which command, if any, each edge must accept. The bus enable and data are compared both after each edge and between edges while oe_ni changes.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic [3:0] {
    CMD_STALL,
    CMD_SLEEP,
    CMD_WAKE,
    CMD_DESEL,
    CMD_DESEL_CONT,
    CMD_RD_BEGIN,
    CMD_RD_CONT,
    CMD_WR_BEGIN,
    CMD_WR_CONT,
    CMD_WA_BEGIN,
    CMD_WA_CONT
  } cmd_e;

  typedef enum logic [1:0] {
    BT_NONE,
    BT_READ,
    BT_WRITE
  } burst_e;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_burst_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce1_ni,
  input  logic             ce2_i,
  input  logic             ce3_ni,
  input  logic             adv_ld_i,
  input  logic             we_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             cen_ni,
  input  logic             zz_i,
  input  logic             wake_busy_i,
  input  burst_e           btype_i,
  output cmd_e             cmd_o
);
  logic desel;
  logic no_lane;

  assign desel   = ce1_ni | ce3_ni | ~ce2_i;
  assign no_lane = &bw_ni;

  // priority: sleep > wake hold > stall > load > continue
  always_comb begin
    if (zz_i)             cmd_o = CMD_SLEEP;
    else if (wake_busy_i) cmd_o = CMD_WAKE;
    else if (cen_ni)      cmd_o = CMD_STALL;
    else if (!adv_ld_i) begin
      if (desel)          cmd_o = CMD_DESEL;
      else if (we_ni)     cmd_o = CMD_RD_BEGIN;
      else if (no_lane)   cmd_o = CMD_WA_BEGIN;
      else                cmd_o = CMD_WR_BEGIN;
    end else begin
      case (btype_i)
        BT_READ:  cmd_o = CMD_RD_CONT;
        BT_WRITE: cmd_o = no_lane ? CMD_WA_CONT : CMD_WR_CONT;
        default:  cmd_o = CMD_DESEL_CONT;
      endcase
    end
  end
endmodule

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr #(
  parameter int ADDR_W     = 6,
  parameter int BURST_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0]     base_q;
  logic [BURST_BITS-1:0] cnt_q;
  logic [BURST_BITS-1:0] cnt_nxt;
  logic [BURST_BITS-1:0] lo;

  assign cnt_nxt = cnt_q + 1'b1;
  // interleaved order flips base bits; linear order adds
  assign lo      = mode_i ? (base_q[BURST_BITS-1:0] ^ cnt_nxt)
                          : (base_q[BURST_BITS-1:0] + cnt_nxt);
  assign addr_o  = load_i ? addr_i : {base_q[ADDR_W-1:BURST_BITS], lo};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
    end else if (adv_i) begin
      cnt_q  <= cnt_nxt;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> cnt_q == BURST_BITS'($past(cnt_q) + 1'b1)); // R3
  AST_LOAD_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> base_q == $past(addr_i) && cnt_q == '0); // R2
endmodule

// File: rtl/sram_word_array.sv
module sram_word_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                 clk_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [LANES-1:0]     wr_lane_i,
  input  logic [8*LANES-1:0]   wdata_i,
  output logic [8*LANES-1:0]   rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_lane_i[g]) lane_mem[addr_i] <= wdata_i[8*g +: 8];
    end

    assign rdata_o[8*g +: 8] = lane_mem[addr_i];
  end
endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int LANES       = 4,
  parameter int BURST_BITS  = 2,
  parameter int WAKE_CYCLES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce1_ni,
  input  logic                 ce2_i,
  input  logic                 ce3_ni,
  input  logic                 adv_ld_i,
  input  logic                 we_ni,
  input  logic [LANES-1:0]     bw_ni,
  input  logic                 cen_ni,
  input  logic                 oe_ni,
  input  logic                 zz_i,
  input  logic                 burst_mode_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [8*LANES-1:0]   dq_i,
  output logic [8*LANES-1:0]   dq_o,
  output logic                 dq_oe_o
);
  localparam int DW = 8 * LANES;
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  cmd_e              cmd;
  burst_e            btype_q;
  logic              drive_q;
  logic [DW-1:0]     rdata_q;
  logic [DW-1:0]     mem_rdata;
  logic [WW-1:0]     wake_q;
  logic              wake_busy;
  logic              ctr_load;
  logic              ctr_adv;
  logic              is_wr;
  logic              is_wr_kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  wr_lane;

  assign wake_busy = (wake_q != '0);

  sram_cmd_decode #(.LANES(LANES)) u_decode (
    .ce1_ni      (ce1_ni),
    .ce2_i       (ce2_i),
    .ce3_ni      (ce3_ni),
    .adv_ld_i    (adv_ld_i),
    .we_ni       (we_ni),
    .bw_ni       (bw_ni),
    .cen_ni      (cen_ni),
    .zz_i        (zz_i),
    .wake_busy_i (wake_busy),
    .btype_i     (btype_q),
    .cmd_o       (cmd)
  );

  always_comb begin
    ctr_load   = (cmd == CMD_RD_BEGIN) || (cmd == CMD_WR_BEGIN);
    ctr_adv    = (cmd == CMD_RD_CONT) || (cmd == CMD_WR_CONT) || (cmd == CMD_WA_CONT);
    is_wr      = (cmd == CMD_WR_BEGIN) || (cmd == CMD_WR_CONT);
    is_wr_kind = is_wr || (cmd == CMD_WA_BEGIN) || (cmd == CMD_WA_CONT);
    wr_lane    = is_wr ? ~bw_ni : '0;
  end

  sram_burst_ctr #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctr_load),
    .adv_i  (ctr_adv),
    .mode_i (burst_mode_i),
    .addr_i (addr_i),
    .addr_o (cur_addr)
  );

  sram_word_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
    .clk_i     (clk_i),
    .addr_i    (cur_addr),
    .wr_lane_i (wr_lane),
    .wdata_i   (dq_i),
    .rdata_o   (mem_rdata)
  );

  // recovery window: counts edges after sleep, stalls included
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wake_q <= '0;
    else if (zz_i)      wake_q <= WW'(WAKE_CYCLES);
    else if (wake_busy) wake_q <= wake_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      btype_q <= BT_NONE;
      drive_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (cmd)
        CMD_STALL: ;
        CMD_RD_BEGIN, CMD_RD_CONT: begin
          btype_q <= BT_READ;
          drive_q <= 1'b1;
          rdata_q <= mem_rdata;
        end
        CMD_WR_BEGIN, CMD_WR_CONT, CMD_WA_CONT: begin
          btype_q <= BT_WRITE;
          drive_q <= 1'b0;
        end
        default: begin
          btype_q <= BT_NONE;
          drive_q <= 1'b0;
        end
      endcase
    end
  end

  // output enable bypasses the clock; masked by write state and sleep
  assign dq_oe_o = drive_q & ~oe_ni & ~zz_i;
  assign dq_o    = rdata_q;

  AST_WR_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr_kind |=> !dq_oe_o); // R6
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_STALL |=> $stable(rdata_q) && $stable(drive_q) && $stable(btype_q)); // R10
  AST_SLEEP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(zz_i) |-> !drive_q && btype_q == BT_NONE); // R11
  AST_WAKE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_busy && !zz_i |=> !drive_q); // R11
  AST_DESEL_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btype_q == BT_NONE && adv_ld_i && !cen_ni && !zz_i |=> !drive_q); // R13
endmodule

// File: tb/sram_burst_ctrl_tb.sv
module sram_burst_ctrl_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 6;
  localparam int LN = 4;
  localparam int DW = 8 * LN;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_ni;
  logic          ce1_ni, ce2_i, ce3_ni, adv_ld_i, we_ni, cen_ni, oe_ni, zz_i, mode_i;
  logic [LN-1:0] bw_ni;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] dq_i, dq_o;
  logic          dq_oe_o;

  sram_burst_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce1_ni(ce1_ni), .ce2_i(ce2_i), .ce3_ni(ce3_ni),
    .adv_ld_i(adv_ld_i), .we_ni(we_ni), .bw_ni(bw_ni), .cen_ni(cen_ni), .oe_ni(oe_ni),
    .zz_i(zz_i), .burst_mode_i(mode_i), .addr_i(addr_i), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  logic [DW-1:0] ref_mem [DEPTH];
  int            m_bt, m_cnt, m_wake;
  logic [AW-1:0] m_base;
  logic          m_drive;
  logic [DW-1:0] m_rdata;
  string         m_tag;
  int            n_vec = 0, n_bad = 0;

  function automatic logic [AW-1:0] seq_addr(logic [AW-1:0] b, int c, logic md);
    logic [1:0] lo;
    lo = md ? (b[1:0] ^ 2'(c)) : 2'(b[1:0] + 2'(c));
    return {b[AW-1:2], lo};
  endfunction

  task automatic write_lanes(logic [AW-1:0] a);
    for (int k = 0; k < LN; k++)
      if (!bw_ni[k]) ref_mem[a][8*k +: 8] = dq_i[8*k +: 8];
  endtask

  task automatic step_model();
    logic [AW-1:0] a;
    if (zz_i) begin
      m_wake = 2; m_bt = 0; m_drive = 0; m_tag = "R11";
    end else if (m_wake > 0) begin
      m_wake--; m_bt = 0; m_drive = 0; m_tag = "R11";
    end else if (cen_ni) begin
      m_tag = "R10";
    end else if (!adv_ld_i) begin
      if (ce1_ni || ce3_ni || !ce2_i) begin
        m_bt = 0; m_drive = 0; m_tag = "R1";
      end else if (we_ni) begin
        m_base = addr_i; m_cnt = 0; m_rdata = ref_mem[addr_i];
        m_bt = 1; m_drive = 1; m_tag = "R2";
      end else if (&bw_ni) begin
        m_bt = 0; m_drive = 0; m_tag = "R7";
      end else begin
        m_base = addr_i; m_cnt = 0; write_lanes(addr_i);
        m_bt = 2; m_drive = 0; m_tag = "R5";
      end
    end else begin
      case (m_bt)
        1: begin
          m_cnt = (m_cnt + 1) % 4;
          a = seq_addr(m_base, m_cnt, mode_i);
          m_rdata = ref_mem[a]; m_drive = 1;
          m_tag = mode_i ? "R4" : "R3";
        end
        2: begin
          m_cnt = (m_cnt + 1) % 4;
          a = seq_addr(m_base, m_cnt, mode_i);
          if (!(&bw_ni)) begin write_lanes(a); m_tag = "R6"; end
          else m_tag = "R7";
          m_drive = 0;
        end
        default: begin m_drive = 0; m_tag = "R13"; end
      endcase
    end
  endtask

  task automatic check_bus(string tag);
    logic exp_oe;
    exp_oe = m_drive && !oe_ni && !zz_i;
    n_vec++;
    if (dq_oe_o !== exp_oe || (exp_oe && dq_o !== m_rdata)) begin
      n_bad++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
               tag, dq_oe_o, dq_o, exp_oe, m_rdata);
    end
  endtask

  task automatic cycle(string tag = "");
    @(posedge clk);
    #0.5 step_model();
    #0.5 check_bus(tag == "" ? m_tag : tag);
    @(negedge clk);
  endtask

  task automatic set_cmd(logic sel, logic adv, logic we, logic [LN-1:0] bw,
                         logic [AW-1:0] a, logic [DW-1:0] d);
    ce1_ni = !sel; ce2_i = 1'b1; ce3_ni = 1'b0;
    adv_ld_i = adv; we_ni = we; bw_ni = bw; addr_i = a; dq_i = d;
    cen_ni = 1'b0; zz_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(4ns * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_bt = 0; m_cnt = 0; m_wake = 0; m_base = '0; m_drive = 0; m_rdata = '0; m_tag = "";
    rst_ni = 1'b0; mode_i = 1'b0; oe_ni = 1'b0;
    set_cmd(1'b0, 1'b0, 1'b1, 4'hF, '0, '0);
    repeat (3) @(negedge clk);
    check_bus("R12");                         // R12: reset, oe active, bus off
    rst_ni = 1'b1;
    @(negedge clk);
    check_bus("R12");

    for (int i = 0; i < DEPTH; i++) begin   // prefill, full-lane writes R5
      set_cmd(1'b1, 1'b0, 1'b0, 4'h0, AW'(i), $urandom);
      oe_ni = $urandom % 2;
      cycle("R6");
    end

    // R3: linear order from 6 -> 7,4,5
    mode_i = 1'b0; oe_ni = 1'b0;
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd6, '0); cycle("R2");
    repeat (3) begin set_cmd(1'b0, 1'b1, 1'b1, 4'hF, 6'd0, '0); cycle("R3"); end
    // R4: interleaved order from 9 -> 8,11,10
    mode_i = 1'b1;
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd9, '0); cycle("R2");
    repeat (3) begin set_cmd(1'b0, 1'b1, 1'b1, 4'hF, 6'd0, '0); cycle("R4"); end

    // R8: toggle output enable between edges
    #0.3 oe_ni = 1'b1; #0.3 check_bus("R8");
    #0.3 oe_ni = 1'b0; #0.3 check_bus("R8");

    // R5/R6: partial write, continue write, then read back
    mode_i = 1'b0;
    set_cmd(1'b1, 1'b0, 1'b0, 4'b1010, 6'd20, 32'hA1B2C3D4); cycle("R5");
    set_cmd(1'b1, 1'b1, 1'b0, 4'b0011, 6'd0, 32'h55667788); cycle("R6");
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd20, '0); cycle("R5");
    set_cmd(1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0); cycle("R5");

    // R7: abort begin, then abort continue inside a write burst
    set_cmd(1'b1, 1'b0, 1'b0, 4'hF, 6'd21, 32'hDEADBEEF); cycle("R7");
    set_cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'd0, 32'hDEADBEEF); cycle("R7");
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd21, '0); cycle("R7");
    set_cmd(1'b1, 1'b0, 1'b0, 4'h0, 6'd24, 32'h01020304); cycle("R5");
    set_cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'd0, 32'hFFFFFFFF); cycle("R7");
    set_cmd(1'b1, 1'b1, 1'b0, 4'h0, 6'd0, 32'h0BADF00D); cycle("R5");
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd25, '0); cycle("R7");
    set_cmd(1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0); cycle("R7");

    // R9: dummy reads advance the burst
    oe_ni = 1'b1;
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd32, '0); cycle("R9");
    set_cmd(1'b0, 1'b1, 1'b1, 4'hF, 6'd0, '0); cycle("R9");
    oe_ni = 1'b0;
    set_cmd(1'b0, 1'b1, 1'b1, 4'hF, 6'd0, '0); cycle("R9");

    // R10: stall holds data and burst position
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd40, '0); cycle("R2");
    set_cmd(1'b0, 1'b0, 1'b0, 4'h0, 6'd3, '1); cen_ni = 1'b1; cycle("R10");
    cen_ni = 1'b1; cycle("R10");
    set_cmd(1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0); cycle("R10");

    // R11: sleep while driving, blocked edges after release
    #0.3 zz_i = 1'b1; #0.3 check_bus("R11");
    @(negedge clk);
    set_cmd(1'b1, 1'b0, 1'b0, 4'h0, 6'd44, 32'h12345678); zz_i = 1'b1; cycle("R11");
    cycle("R11");
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd44, '0); cycle("R11");
    cycle("R11");
    cycle("R2");

    // R1: each chip-enable deselect form; R13: continue after deselect
    set_cmd(1'b0, 1'b0, 1'b1, 4'hF, 6'd1, '0); cycle("R1");
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd2, '0); cycle("R2");
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd2, '0); ce2_i = 1'b0; cycle("R1");
    set_cmd(1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0); cycle("R13");
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd3, '0); cycle("R2");
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd3, '0); ce3_ni = 1'b1; cycle("R1");
    set_cmd(1'b1, 1'b1, 1'b0, 4'h0, 6'd0, 32'hCAFECAFE); cycle("R13");
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 6'd0, '0); cycle("R13");

    for (int v = 0; v < 3000; v++) begin
      int pick;
      set_cmd(1'b1, 1'($urandom % 2), 1'($urandom % 2),
              ($urandom % 5 == 0) ? 4'hF : 4'($urandom), AW'($urandom), $urandom);
      pick = $urandom % 12;
      if (pick == 0) ce1_ni = 1'b1;
      else if (pick == 1) ce2_i = 1'b0;
      else if (pick == 2) ce3_ni = 1'b1;
      cen_ni = ($urandom % 10 == 0);
      zz_i   = ($urandom % 33 == 0);
      oe_ni  = ($urandom % 4 == 0);
      mode_i = 1'($urandom % 2);
      cycle();
    end

    finish_run();
  end
endmodule